// File: doc/BRIEF.md
# PWM Down-Counter Channel with Double-Buffered Period and Duty

This block is one PWM timer channel. A programmable prescaler and a power-of-two divider turn the system clock into a count tick. The tick drives a period down counter, and a comparator turns the counter value into a pulse. Software stages a new period and a new compare value in holding registers at any time. The running counter and comparator take up those values only when the count wraps through zero, so a waveform already in progress is never cut short or stretched by a write.

The channel runs either continuously, reloading at every wrap, or for a single period, after which it halts. Every wrap sets a sticky event flag. Software clears the flag by pulsing a clear input, and the flag raises an interrupt request only when its enable is set. An optional pair mode adds a second, complementary output. In pair mode both outputs have their rising edges held back by a programmable dead time, so the two outputs never overlap.

Top module: `pwm_dbuf_channel`

## Requirements
- R1: The counter steps once every (pre_div+1)·2^k clock cycles, where k is div_sel for codes 0 to 4 and 4 for codes 5 to 7. The first step comes one full interval after the load.
- R2: After reset, pwm_a, pwm_b, flag and irq are all 0.
- R3: On the first cycle that run_en is 1 after being 0, the counter loads from the period holding register and the comparator loads from the compare holding register.
- R4: A write to period_data/period_wr or cmp_data/cmp_wr while running changes nothing at the outputs until the counter next wraps through zero.
- R5: In reload mode (oneshot=0), a step taken at count 0 reloads the period value. Each period therefore lasts P+1 steps.
- R6: With pair mode off, pwm_a is 1 while the channel runs and the count is at or below the compare value C. This gives C+1 high steps per period, and the output stays high for the whole period when C ≥ P.
- R7: In one-shot mode (oneshot=1), the step taken at count 0 halts the channel. Both outputs then stay 0 until run_en is cleared and set again.
- R8: Each step at count 0 sets flag. A flag_clr pulse clears it, but a zero step in the same cycle as the clear wins and the flag stays set.
- R9: irq is 1 exactly when flag is 1 and irq_en is 1.
- R10: With run_en at 0 the counter holds its value, and both outputs are 0 from the next cycle on.
- R11: With pair_en=1, pwm_b is the running complement of the pulse. Each output rises only after its source has been high for dead_ticks prescaler ticks, and the two outputs are never high together.
- R12: With pair_en=0, pwm_b stays 0 and pwm_a follows the pulse with no delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Run enable; a rising value restarts from the holding registers |
| oneshot | input | 1 | 1 selects single-period mode, 0 selects reload mode |
| pre_div | input | 8 | Prescaler terminal value; divides by pre_div+1 |
| div_sel | input | 3 | Divider select: 1, 2, 4, 8, or 16 for codes 4 and up |
| period_wr | input | 1 | Write strobe for the period holding register |
| period_data | input | 16 | Period value to stage |
| cmp_wr | input | 1 | Write strobe for the compare holding register |
| cmp_data | input | 16 | Compare value to stage |
| flag_clr | input | 1 | Write-one pulse that clears the wrap flag |
| irq_en | input | 1 | Interrupt enable for the wrap flag |
| pair_en | input | 1 | Enables the complementary output with dead time |
| dead_ticks | input | 8 | Dead time in prescaler ticks |
| pwm_a | output | 1 | Main PWM output |
| pwm_b | output | 1 | Complementary output (pair mode only) |
| flag | output | 1 | Sticky wrap event flag |
| irq | output | 1 | Interrupt request |

## Verification
A corrupted count or a stale comparator shows up as a wrong pwm_a level, at the latest one period after the fault. A broken reload shows up through the spacing of flag events. A wrong prescaler or divider state moves the next edge by at least one clock, so a cycle-by-cycle comparison against an independent model of the requirements catches it within one tick interval. A faulty dead-time counter changes how long pwm_a or pwm_b is delayed after a transition, or lets the two outputs overlap, in the very period where it happens.

// File: rtl/pwm_chan_pkg.sv
package pwm_chan_pkg;

    // Largest divider exponent: the divider saturates at 2**DIV_EXP_MAX.
    localparam int DIV_EXP_MAX = 4;

    typedef enum logic {
        RELOAD_MODE  = 1'b0,
        ONESHOT_MODE = 1'b1
    } pwm_mode_e;

    // Clamp a divider select code to the supported exponent range.
    function automatic int unsigned sat_exp(input int unsigned code);
        return (code > DIV_EXP_MAX) ? DIV_EXP_MAX : code;
    endfunction

endpackage

// File: rtl/pwm_tick_gen.sv
module pwm_tick_gen #(
    parameter int PRE_W = 8,
    parameter int SEL_W = 3,
    parameter int DIV_W = pwm_chan_pkg::DIV_EXP_MAX
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [PRE_W-1:0] pre_div,
    input  logic [SEL_W-1:0] div_sel,
    output logic             pre_tick,
    output logic             tick
);
    import pwm_chan_pkg::*;

    typedef struct packed {
        logic [PRE_W-1:0] pre;
        logic [DIV_W-1:0] div;
    } tg_state_t;

    tg_state_t s_d, s_q;
    logic [DIV_W-1:0] mask_c;

    always_comb begin
        s_d      = s_q;
        mask_c   = DIV_W'((1 << sat_exp(int'(div_sel))) - 1);
        pre_tick = en && (s_q.pre >= pre_div);
        tick     = pre_tick && ((s_q.div & mask_c) == mask_c);
        if (!en) begin
            s_d = '0;
        end else if (pre_tick) begin
            s_d.pre = '0;
            s_d.div = s_q.div + DIV_W'(1);
        end else begin
            s_d.pre = s_q.pre + PRE_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R1: once the prescaler reaches its terminal value it restarts from zero
    p_pre_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        pre_tick |=> (s_q.pre == '0));

endmodule

// File: rtl/pwm_period_core.sv
module pwm_period_core #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic             oneshot,
    input  logic             tick,
    input  logic             period_wr,
    input  logic [CNT_W-1:0] period_data,
    input  logic             cmp_wr,
    input  logic [CNT_W-1:0] cmp_data,
    input  logic             flag_clr,
    output logic             active,
    output logic             pulse,
    output logic             pulse_n,
    output logic             flag
);
    import pwm_chan_pkg::*;

    typedef struct packed {
        logic             run;
        logic             act;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] cmp;
        logic [CNT_W-1:0] pbuf;
        logic [CNT_W-1:0] cbuf;
        logic             flag;
    } core_state_t;

    core_state_t s_d, s_q;
    pwm_mode_e   mode;
    logic        start_c;
    logic        zero_c;

    assign mode = pwm_mode_e'(oneshot);

    always_comb begin
        s_d     = s_q;
        s_d.run = run_en;
        start_c = run_en && !s_q.run;
        zero_c  = 1'b0;
        if (!run_en) begin
            s_d.act = 1'b0;
        end else if (start_c) begin
            s_d.act = 1'b1;
            s_d.cnt = s_q.pbuf;
            s_d.cmp = s_q.cbuf;
        end else if (s_q.act && tick) begin
            if (s_q.cnt == '0) begin
                zero_c = 1'b1;
                if (mode == ONESHOT_MODE) begin
                    s_d.act = 1'b0;
                end else begin
                    s_d.cnt = s_q.pbuf;
                    s_d.cmp = s_q.cbuf;
                end
            end else begin
                s_d.cnt = s_q.cnt - CNT_W'(1);
            end
        end
        if (zero_c)        s_d.flag = 1'b1;
        else if (flag_clr) s_d.flag = 1'b0;
        if (period_wr) s_d.pbuf = period_data;
        if (cmp_wr)    s_d.cbuf = cmp_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign active  = s_q.act;
    assign pulse   = s_q.act && (s_q.cnt <= s_q.cmp);
    assign pulse_n = s_q.act && (s_q.cnt >  s_q.cmp);
    assign flag    = s_q.flag;

    // R8: a zero step always leaves the flag set
    p_flag_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        zero_c |=> flag);

    // R10: a stopped channel holds its count and drives nothing
    p_freeze_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> ($stable(s_q.cnt) && !pulse && !pulse_n));

    // R7: a zero step in one-shot mode halts the channel
    p_oneshot_halt_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (zero_c && oneshot) |=> !active);

    // R5: a zero step in reload mode restarts from the staged period
    p_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (zero_c && !oneshot) |=> (s_q.cnt == $past(s_q.pbuf)));

endmodule

// File: rtl/pwm_deadband.sv
module pwm_deadband #(
    parameter int DT_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pair_en,
    input  logic            pre_tick,
    input  logic [DT_W-1:0] dead,
    input  logic            src_a,
    input  logic            src_b,
    output logic            out_a,
    output logic            out_b
);
    localparam int LANES = 2;

    logic [LANES-1:0] src;
    logic [LANES-1:0] ready;

    assign src = {src_b, src_a};

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [DT_W-1:0] dz_d, dz_q;

        always_comb begin
            dz_d = dz_q;
            if (!src[g])                         dz_d = '0;
            else if (pre_tick && (dz_q < dead))  dz_d = dz_q + DT_W'(1);
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) dz_q <= '0;
            else        dz_q <= dz_d;
        end

        assign ready[g] = src[g] && (dz_q >= dead);
    end

    assign out_a = pair_en ? ready[0] : src[0];
    assign out_b = pair_en ? ready[1] : 1'b0;

    // R11: complementary outputs never overlap
    p_no_overlap_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_a && out_b));

    // R11: a fresh rising source is held back while a dead time is set
    p_dead_delay_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (pair_en && $rose(src_a) && (dead != '0)) |-> !out_a);

endmodule

// File: rtl/pwm_dbuf_channel.sv
module pwm_dbuf_channel #(
    parameter int CNT_W = 16,
    parameter int PRE_W = 8,
    parameter int SEL_W = 3,
    parameter int DT_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic             oneshot,
    input  logic [PRE_W-1:0] pre_div,
    input  logic [SEL_W-1:0] div_sel,
    input  logic             period_wr,
    input  logic [CNT_W-1:0] period_data,
    input  logic             cmp_wr,
    input  logic [CNT_W-1:0] cmp_data,
    input  logic             flag_clr,
    input  logic             irq_en,
    input  logic             pair_en,
    input  logic [DT_W-1:0]  dead_ticks,
    output logic             pwm_a,
    output logic             pwm_b,
    output logic             flag,
    output logic             irq
);
    logic active, pre_tick, tick, pulse, pulse_n;

    pwm_tick_gen #(.PRE_W(PRE_W), .SEL_W(SEL_W)) u_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (active && run_en),
        .pre_div  (pre_div),
        .div_sel  (div_sel),
        .pre_tick (pre_tick),
        .tick     (tick)
    );

    pwm_period_core #(.CNT_W(CNT_W)) u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .run_en      (run_en),
        .oneshot     (oneshot),
        .tick        (tick),
        .period_wr   (period_wr),
        .period_data (period_data),
        .cmp_wr      (cmp_wr),
        .cmp_data    (cmp_data),
        .flag_clr    (flag_clr),
        .active      (active),
        .pulse       (pulse),
        .pulse_n     (pulse_n),
        .flag        (flag)
    );

    pwm_deadband #(.DT_W(DT_W)) u_dead (
        .clk      (clk),
        .rst_n    (rst_n),
        .pair_en  (pair_en),
        .pre_tick (pre_tick),
        .dead     (dead_ticks),
        .src_a    (pulse),
        .src_b    (pulse_n),
        .out_a    (pwm_a),
        .out_b    (pwm_b)
    );

    assign irq = flag && irq_en;

endmodule

// File: tb/pwm_dbuf_channel_bench.sv
`timescale 1ns/1ps
module pwm_dbuf_channel_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run_en = 0, oneshot = 0, period_wr = 0, cmp_wr = 0;
    logic        flag_clr = 0, irq_en = 0, pair_en = 0;
    logic [7:0]  pre_div = 0, dead_ticks = 0;
    logic [2:0]  div_sel = 0;
    logic [15:0] period_data = 0, cmp_data = 0;
    logic        pwm_a, pwm_b, flag, irq;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    bit model_on = 0;
    bit done     = 0;

    always #2.5 clk = ~clk;

    pwm_dbuf_channel u_pwm_dbuf_channel (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .oneshot(oneshot),
        .pre_div(pre_div), .div_sel(div_sel), .period_wr(period_wr),
        .period_data(period_data), .cmp_wr(cmp_wr), .cmp_data(cmp_data),
        .flag_clr(flag_clr), .irq_en(irq_en), .pair_en(pair_en),
        .dead_ticks(dead_ticks), .pwm_a(pwm_a), .pwm_b(pwm_b),
        .flag(flag), .irq(irq)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d expected=%0d (t=%0t)", req, what, act, exp, $time);
        end
    endtask

    // ---------------- reference model of the requirements ----------------
    int m_pre, m_div, m_cnt, m_cmp, m_pbuf, m_cbuf, m_dz0, m_dz1;
    bit m_run, m_act, m_flag;

    function automatic int step_len_exp(input int sel);
        return (sel > 4) ? 4 : sel;                       // R1 saturation
    endfunction

    always @(posedge clk) begin : model
        bit en, ptick, tk, sa, sb, zero;
        int mask, nz0, nz1;
        if (!rst_n) begin
            m_pre = 0; m_div = 0; m_cnt = 0; m_cmp = 0; m_pbuf = 0; m_cbuf = 0;
            m_dz0 = 0; m_dz1 = 0; m_run = 0; m_act = 0; m_flag = 0;
        end else begin
            en    = m_act && run_en;
            mask  = (1 << step_len_exp(int'(div_sel))) - 1;
            ptick = en && (m_pre >= int'(pre_div));
            tk    = ptick && ((m_div & mask) == mask);
            sa    = m_act && (m_cnt <= m_cmp);
            sb    = m_act && (m_cnt >  m_cmp);
            nz0   = !sa ? 0 : ((ptick && m_dz0 < int'(dead_ticks)) ? m_dz0 + 1 : m_dz0);
            nz1   = !sb ? 0 : ((ptick && m_dz1 < int'(dead_ticks)) ? m_dz1 + 1 : m_dz1);
            if (!en) begin m_pre = 0; m_div = 0; end
            else if (ptick) begin m_pre = 0; m_div = (m_div + 1) & 15; end
            else m_pre = m_pre + 1;
            zero = 0;
            if (!run_en) m_act = 0;
            else if (!m_run) begin m_act = 1; m_cnt = m_pbuf; m_cmp = m_cbuf; end
            else if (m_act && tk) begin
                if (m_cnt == 0) begin
                    zero = 1;
                    if (oneshot) m_act = 0;
                    else begin m_cnt = m_pbuf; m_cmp = m_cbuf; end
                end else m_cnt = m_cnt - 1;
            end
            if (zero) m_flag = 1;
            else if (flag_clr) m_flag = 0;
            if (period_wr) m_pbuf = int'(period_data);
            if (cmp_wr)    m_cbuf = int'(cmp_data);
            m_run = run_en; m_dz0 = nz0; m_dz1 = nz1;
        end
    end

    always @(negedge clk) begin : compare
        bit eb, en_b, ea, ebb;
        #1;
        if (model_on && !done) begin
            eb   = m_act && (m_cnt <= m_cmp);
            en_b = m_act && (m_cnt >  m_cmp);
            ea   = pair_en ? (eb && m_dz0 >= int'(dead_ticks)) : eb;
            ebb  = pair_en ? (en_b && m_dz1 >= int'(dead_ticks)) : 1'b0;
            chk("R6/R4/R3", "pwm_a vs model", int'(pwm_a), int'(ea));
            if (pwm_b !== ebb) chk("R11", "pwm_b vs model", int'(pwm_b), int'(ebb));
            if (flag !== m_flag) chk("R8", "flag vs model", int'(flag), int'(m_flag));
            if (irq !== (m_flag && irq_en)) chk("R9", "irq vs model", int'(irq), int'(m_flag && irq_en));
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1;
            n_checks++; n_fail++;
            $display("FAIL watchdog: cycles actual=%0d expected<=150000", cyc);
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    // ---------------- directed helpers ----------------
    task automatic configure(input int pre, input int dsel, input int per, input int cmpv,
                             input bit os, input bit pr, input int dt);
        @(negedge clk);
        run_en = 0;
        @(negedge clk);
        pre_div = 8'(pre); div_sel = 3'(dsel); oneshot = os; pair_en = pr;
        dead_ticks = 8'(dt);
        period_wr = 1; period_data = 16'(per);
        cmp_wr = 1; cmp_data = 16'(cmpv);
        @(negedge clk);
        period_wr = 0; cmp_wr = 0;
        run_en = 1;
    endtask

    task automatic measure(input int n, output int ha, output int hb, output int both, output int hf);
        ha = 0; hb = 0; both = 0; hf = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk); #1;
            if (pwm_a) ha++;
            if (pwm_b) hb++;
            if (pwm_a && pwm_b) both++;
            if (flag) hf++;
        end
    endtask

    initial begin
        int ha, hb, both, hf;
        void'($urandom(32'd20517));
        repeat (4) @(negedge clk);
        rst_n = 1;
        #1;
        chk("R2", "pwm_a after reset", int'(pwm_a), 0);
        chk("R2", "pwm_b after reset", int'(pwm_b), 0);
        chk("R2", "flag after reset",  int'(flag), 0);
        chk("R2", "irq after reset",   int'(irq), 0);
        model_on = 1;

        // R6 / R12 / R5: P=9, C=3, one clock per step
        configure(0, 0, 9, 3, 0, 0, 0);
        repeat (5) @(negedge clk);
        flag_clr = 1;
        measure(20, ha, hb, both, hf);
        flag_clr = 0;
        chk("R6", "high cycles P=9 C=3 in 20", ha, 8);
        chk("R12", "pwm_b high with pair off", hb, 0);
        chk("R5", "wrap events in 20 cycles", hf, 2);

        // R4 / R6: staged compare above period -> full duty after next wrap
        @(negedge clk); cmp_wr = 1; cmp_data = 16'd12;
        @(negedge clk); cmp_wr = 0;
        repeat (25) @(negedge clk);
        measure(20, ha, hb, both, hf);
        chk("R6", "full duty with C>=P", ha, 20);

        // R1: pre_div=1, div /4 -> 8 clocks per step, P=4 C=1
        configure(1, 2, 4, 1, 0, 0, 0);
        repeat (3) @(negedge clk);
        measure(80, ha, hb, both, hf);
        chk("R1", "high cycles pre=1 div=4", ha, 32);

        // R1: divider code 6 saturates at 16, P=1 C=0
        configure(0, 6, 1, 0, 0, 0, 0);
        repeat (3) @(negedge clk);
        measure(64, ha, hb, both, hf);
        chk("R1", "high cycles div code 6", ha, 32);

        // R7 / R9 / R8: one-shot, P=3 C=1
        @(negedge clk); run_en = 0; flag_clr = 1; irq_en = 0;
        @(negedge clk); flag_clr = 0;
        configure(0, 0, 3, 1, 1, 0, 0);
        measure(20, ha, hb, both, hf);
        chk("R7", "one-shot high cycles", ha, 2);
        chk("R7", "pwm_a after one-shot", int'(pwm_a), 0);
        chk("R8", "flag after one-shot", int'(flag), 1);
        chk("R9", "irq with enable off", int'(irq), 0);
        @(negedge clk); irq_en = 1; #1;
        chk("R9", "irq with enable on", int'(irq), 1);
        @(negedge clk); flag_clr = 1;
        @(negedge clk); flag_clr = 0; #1;
        chk("R8", "flag after clear", int'(flag), 0);
        irq_en = 0;

        // R10: stopping forces low
        configure(0, 0, 9, 9, 0, 0, 0);
        repeat (5) @(negedge clk);
        #1; chk("R6", "pwm_a high C=P", int'(pwm_a), 1);
        @(negedge clk); run_en = 0;
        @(negedge clk); #1;
        chk("R10", "pwm_a after stop", int'(pwm_a), 0);
        chk("R10", "pwm_b after stop", int'(pwm_b), 0);

        // R11: pair mode, dead time 3, P=9 C=4
        configure(0, 0, 9, 4, 0, 1, 3);
        repeat (5) @(negedge clk);
        measure(20, ha, hb, both, hf);
        chk("R11", "pwm_a high with dead 3", ha, 4);
        chk("R11", "pwm_b high with dead 3", hb, 4);
        chk("R11", "overlap cycles", both, 0);

        // constrained random against the model (R3, R4, R8 set-wins etc.)
        for (int i = 0; i < 8000; i++) begin
            @(negedge clk);
            period_wr   = ($urandom % 20) == 0;
            period_data = 16'($urandom % 21);
            cmp_wr      = ($urandom % 20) == 0;
            cmp_data    = 16'($urandom % 25);
            flag_clr    = ($urandom % 6) == 0;
            if (($urandom % 50)  == 0) irq_en  = ~irq_en;
            if (($urandom % 150) == 0) run_en  = ~run_en;
            if (($urandom % 300) == 0) oneshot = ~oneshot;
            if (($urandom % 200) == 0) pair_en = ~pair_en;
            if (($urandom % 200) == 0) dead_ticks = 8'($urandom % 6);
            if (($urandom % 300) == 0) pre_div = 8'($urandom % 4);
            if (($urandom % 300) == 0) div_sel = 3'($urandom % 8);
            if (!run_en && ($urandom % 10) == 0) run_en = 1;
        end
        @(negedge clk);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule